// File: doc/BRIEF.md
# Flash command sequence interpreter

This block models the command front end of a byte-wide NOR flash driven in parallel programming mode. The host supplies each bus cycle over a half-width multiplexed address port. The upper address half is taken when the row/column strobe falls, and the lower half when it rises. Write data is taken when write enable rises. All strobes are sampled on the block clock, and edges are detected from one registered copy of each strobe.

A small decoder checks the lock-protected command cycles and starts one of four operations on a parameterised register-file array:
- byte program;
- sector erase;
- block erase;
- whole-array erase.

A cycle-counted busy timer then runs. While it runs, every write is dropped and reads return a polling status byte in place of array data. When the timer expires, reads return array contents again.

Top module: `flash_cmd_front`

## Requirements
- R1: The upper half of the 16-bit bus address is captured when `rc_n` falls, and the lower half when `rc_n` rises. Data is taken when `we_n` rises. The array byte used is the low `ARR_W` bits of the assembled address.
- R2: Program needs four writes: AAh to 5555h, 55h to 2AAAh, A0h to 5555h, then the data to the target address. The stored byte becomes the old byte AND the written data, so bits can only be cleared.
- R3: The erase prefix is AAh to 5555h, 55h to 2AAAh, 80h to 5555h, AAh to 5555h, 55h to 2AAAh. A sixth write of 30h to any address sets every byte of the aligned 2^`SEC_W`-byte sector holding that address to FFh.
- R4: The erase prefix followed by 50h at any address sets every byte of the aligned 2^`BLK_W`-byte block holding that address to FFh.
- R5: The erase prefix followed by 10h at 5555h sets the whole array to FFh. 10h at any other address starts nothing.
- R6: A write that does not match the cycle expected next returns the decoder to idle, and the array is left unchanged. This includes an unknown sixth-cycle code.
- R7: A program keeps the block busy for `PROG_CYCLES` clocks, and an erase for `ERASE_CYCLES` clocks. Every write made while busy is ignored.
- R8: While busy and `oe_n` is low, bit 7 of the output is the inverse of bit 7 of the data being programmed, or 0 during an erase. Bit 6 flips on each falling edge of `oe_n` and reads 1 on the first read after the start. Bits 5..0 read 0.
- R9: When not busy, low `oe_n` drives the array byte at the latched address. High `oe_n` drives 00h.
- R10: After reset every array byte reads FFh, the decoder is idle and the block is not busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all strobes sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rc_n | input | 1 | Row/column strobe: fall takes the upper address half, rise the lower |
| we_n | input | 1 | Write enable, active low; data taken on its rise |
| oe_n | input | 1 | Output enable, active low |
| addr_in | input | BUS_AW/2 | Multiplexed address half |
| data_in | input | 8 | Write data |
| data_out | output | 8 | Array byte, polling status, or 00h when output is disabled |

## Verification
On every cycle the assertions check several timing and output rules:
- the busy window lasts exactly the configured count for the operation started;
- no operation starts while busy;
- the toggle bit flips on each output-enable fall during busy;
- the low status bits stay zero, and bit 7 is zero during erase;
- the output is zero whenever output enable is high.

The bench scenarios cover what needs a reference model. They confirm that each erase size clears the right aligned region and nothing else. They confirm that programming ANDs into the old byte and that addresses are assembled from the right strobe edges. They also confirm that aborted sequences, wrong codes and writes made while busy leave the array untouched, checked by reading it back after the operation completes.

// File: rtl/flash_pkg.sv
package flash_pkg;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_PROG = 3'd1,
    OP_SECT = 3'd2,
    OP_BLK  = 3'd3,
    OP_CHIP = 3'd4
  } op_kind_e;

  localparam logic [15:0] KEY_ADDR_A = 16'h5555;
  localparam logic [15:0] KEY_ADDR_B = 16'h2AAA;
  localparam logic [7:0]  KEY_BYTE_A = 8'hAA;
  localparam logic [7:0]  KEY_BYTE_B = 8'h55;
  localparam logic [7:0]  CODE_PROG  = 8'hA0;
  localparam logic [7:0]  CODE_ERPRE = 8'h80;
  localparam logic [7:0]  CODE_SECT  = 8'h30;
  localparam logic [7:0]  CODE_BLK   = 8'h50;
  localparam logic [7:0]  CODE_CHIP  = 8'h10;

  // True when byte index idx falls inside the region an erase of kind op aimed at tgt clears.
  function automatic logic erase_hit(input op_kind_e op, input logic [15:0] idx,
                                     input logic [15:0] tgt, input int sec_w, input int blk_w);
    case (op)
      OP_SECT: return (idx >> sec_w) == (tgt >> sec_w);
      OP_BLK:  return (idx >> blk_w) == (tgt >> blk_w);
      OP_CHIP: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // Status byte seen on reads while busy.
  function automatic logic [7:0] poll_byte(input logic inv7, input logic tog);
    return {inv7, tog, 6'b000000};
  endfunction

endpackage

// File: rtl/flash_bus_capture.sv
module flash_bus_capture #(
  parameter int HALF = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rc_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [HALF-1:0]   addr_in,
  output logic [2*HALF-1:0] bus_addr,
  output logic              wr_evt,
  output logic              rd_evt
);
  logic rc_q, we_q, oe_q;
  logic [HALF-1:0] row_r, col_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rc_q  <= 1'b1;
      we_q  <= 1'b1;
      oe_q  <= 1'b1;
      row_r <= '0;
      col_r <= '0;
    end else begin
      rc_q <= rc_n;
      we_q <= we_n;
      oe_q <= oe_n;
      if (rc_q && !rc_n) row_r <= addr_in;
      if (!rc_q && rc_n) col_r <= addr_in;
    end
  end

  assign bus_addr = {row_r, col_r};
  assign wr_evt   = !we_q && we_n;
  assign rd_evt   = oe_q && !oe_n;
endmodule

// File: rtl/flash_seq_decoder.sv
module flash_seq_decoder
  import flash_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_evt,
  input  logic [15:0] wr_addr,
  input  logic [7:0]  wr_data,
  output op_kind_e    start_op,
  output logic [15:0] tgt_addr,
  output logic [7:0]  tgt_data
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_K1, ST_K2, ST_PDATA, ST_E3, ST_E4, ST_E5
  } seq_e;

  seq_e st;
  logic key_a, key_b, at_a;

  assign at_a  = wr_addr == KEY_ADDR_A;
  assign key_a = at_a && wr_data == KEY_BYTE_A;
  assign key_b = wr_addr == KEY_ADDR_B && wr_data == KEY_BYTE_B;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      start_op <= OP_NONE;
      tgt_addr <= '0;
      tgt_data <= '0;
    end else begin
      start_op <= OP_NONE;
      if (wr_evt) begin
        st <= ST_IDLE;
        case (st)
          ST_IDLE: if (key_a) st <= ST_K1;
          ST_K1:   if (key_b) st <= ST_K2;
          ST_K2: begin
            if (at_a && wr_data == CODE_PROG)       st <= ST_PDATA;
            else if (at_a && wr_data == CODE_ERPRE) st <= ST_E3;
          end
          ST_PDATA: begin
            start_op <= OP_PROG;
            tgt_addr <= wr_addr;
            tgt_data <= wr_data;
          end
          ST_E3: if (key_a) st <= ST_E4;
          ST_E4: if (key_b) st <= ST_E5;
          ST_E5: begin
            tgt_addr <= wr_addr;
            tgt_data <= wr_data;
            if (wr_data == CODE_SECT)             start_op <= OP_SECT;
            else if (wr_data == CODE_BLK)         start_op <= OP_BLK;
            else if (wr_data == CODE_CHIP && at_a) start_op <= OP_CHIP;
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/flash_busy_timer.sv
module flash_busy_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] len,
  output logic             busy
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= len - 1'b1;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/flash_array.sv
module flash_array
  import flash_pkg::*;
#(
  parameter int ARR_W = 8,
  parameter int SEC_W = 4,
  parameter int BLK_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  op_kind_e         op,
  input  logic [15:0]      tgt_addr,
  input  logic [7:0]       tgt_data,
  input  logic [ARR_W-1:0] rd_idx,
  output logic [7:0]       rd_data
);
  localparam int DEPTH = 1 << ARR_W;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (!rst_n) begin
        mem[i] <= 8'hFF;
      end else if (op == OP_PROG) begin
        if (ARR_W'(tgt_addr) == ARR_W'(i)) mem[i] <= mem[i] & tgt_data;
      end else if (erase_hit(op, 16'(i), 16'(ARR_W'(tgt_addr)), SEC_W, BLK_W)) begin
        mem[i] <= 8'hFF;
      end
    end
  end

  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/flash_cmd_front.sv
module flash_cmd_front
  import flash_pkg::*;
#(
  parameter int BUS_AW       = 16,
  parameter int ARR_W        = 8,
  parameter int SEC_W        = 4,
  parameter int BLK_W        = 6,
  parameter int PROG_CYCLES  = 20,
  parameter int ERASE_CYCLES = 200
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rc_n,
  input  logic                we_n,
  input  logic                oe_n,
  input  logic [BUS_AW/2-1:0] addr_in,
  input  logic [7:0]          data_in,
  output logic [7:0]          data_out
);
  localparam int HALF  = BUS_AW / 2;
  localparam int LONG  = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CNT_W = $clog2(LONG + 1);

  logic [BUS_AW-1:0] bus_addr;
  logic              wr_evt, rd_evt, busy;
  logic              wr_ok;
  op_kind_e          start_op;
  logic [15:0]       tgt_addr;
  logic [7:0]        tgt_data;
  logic [7:0]        arr_byte;
  logic [CNT_W-1:0]  op_len;
  logic              inv7_r, tog_r;

  flash_bus_capture #(.HALF(HALF)) u_cap (
    .clk(clk), .rst_n(rst_n), .rc_n(rc_n), .we_n(we_n), .oe_n(oe_n),
    .addr_in(addr_in), .bus_addr(bus_addr), .wr_evt(wr_evt), .rd_evt(rd_evt)
  );

  // writes reach the decoder only when idle
  assign wr_ok = wr_evt && !busy;

  flash_seq_decoder u_dec (
    .clk(clk), .rst_n(rst_n), .wr_evt(wr_ok), .wr_addr(16'(bus_addr)),
    .wr_data(data_in), .start_op(start_op), .tgt_addr(tgt_addr), .tgt_data(tgt_data)
  );

  assign op_len = (start_op == OP_PROG) ? CNT_W'(PROG_CYCLES) : CNT_W'(ERASE_CYCLES);

  flash_busy_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(start_op != OP_NONE), .len(op_len), .busy(busy)
  );

  flash_array #(.ARR_W(ARR_W), .SEC_W(SEC_W), .BLK_W(BLK_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .op(start_op), .tgt_addr(tgt_addr), .tgt_data(tgt_data),
    .rd_idx(bus_addr[ARR_W-1:0]), .rd_data(arr_byte)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inv7_r <= 1'b0;
      tog_r  <= 1'b0;
    end else if (start_op != OP_NONE) begin
      inv7_r <= (start_op == OP_PROG) ? ~tgt_data[7] : 1'b0;
      tog_r  <= 1'b0;
    end else if (busy && rd_evt) begin
      tog_r <= ~tog_r;
    end
  end

  always_comb begin
    if (oe_n)      data_out = 8'h00;
    else if (busy) data_out = poll_byte(inv7_r, tog_r);
    else           data_out = arr_byte;
  end
endmodule

// File: rtl/flash_cmd_front_chk.sv
module flash_cmd_front_chk
  import flash_pkg::*;
#(
  parameter int PROG_CYCLES  = 20,
  parameter int ERASE_CYCLES = 200
) (
  input logic       clk,
  input logic       rst_n,
  input logic       oe_n,
  input logic [7:0] data_out,
  input logic       busy,
  input logic       rd_evt,
  input logic       tog,
  input op_kind_e   op_start
);
  int   run_cnt;
  int   exp_len;
  logic erasing;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_cnt <= 0;
      exp_len <= 0;
      erasing <= 1'b0;
    end else if (op_start != OP_NONE) begin
      run_cnt <= 0;
      exp_len <= (op_start == OP_PROG) ? PROG_CYCLES : ERASE_CYCLES;
      erasing <= op_start != OP_PROG;
    end else if (busy) begin
      run_cnt <= run_cnt + 1;
    end
  end

  // R7
  no_start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> op_start == OP_NONE);

  // R7
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run_cnt == exp_len);

  // R8
  poll_low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !oe_n) |-> data_out[5:0] == 6'b0);

  // R8
  poll_erase_dq7_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && erasing && !oe_n) |-> !data_out[7]);

  // R8
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_evt) |=> tog != $past(tog));

  // R9
  idle_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> data_out == 8'h00);
endmodule

bind flash_cmd_front flash_cmd_front_chk #(
  .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .data_out(data_out), .busy(busy),
  .rd_evt(rd_evt), .tog(tog_r), .op_start(start_op)
);

// File: tb/flash_cmd_front_test.sv
module flash_cmd_front_test;
  localparam int CLK_PERIOD = 10;
  localparam int PROG_N  = 20;
  localparam int ERASE_N = 200;
  localparam int SEC_SZ  = 16;
  localparam int BLK_SZ  = 64;

  logic clk = 1'b0, rst_n = 1'b0, rc_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [7:0] addr_in = '0, data_in = '0;
  logic [7:0] data_out;

  int checks = 0, errors = 0;
  logic done = 1'b0;
  logic [7:0] ref_mem [256];

  always #(CLK_PERIOD / 2) clk = ~clk;

  flash_cmd_front #(.PROG_CYCLES(PROG_N), .ERASE_CYCLES(ERASE_N)) uut (
    .clk(clk), .rst_n(rst_n), .rc_n(rc_n), .we_n(we_n), .oe_n(oe_n),
    .addr_in(addr_in), .data_in(data_in), .data_out(data_out)
  );

  // kind: 1 program, 2 sector erase, 3 block erase, 4 chip erase, 5 read-compare
  localparam int NV = 17;
  localparam logic [27:0] VEC [NV] = '{
    {4'd1, 16'h0012, 8'h5A}, {4'd5, 16'h0012, 8'h00},
    {4'd1, 16'h0012, 8'hF0}, {4'd5, 16'h0012, 8'h00},
    {4'd1, 16'h0034, 8'h00}, {4'd1, 16'h0047, 8'h3C},
    {4'd1, 16'h0088, 8'h11}, {4'd1, 16'h00C1, 8'h22},
    {4'd2, 16'h0035, 8'h30}, {4'd5, 16'h0034, 8'h00},
    {4'd5, 16'h0012, 8'h00}, {4'd3, 16'h0050, 8'h50},
    {4'd5, 16'h0047, 8'h00}, {4'd5, 16'h0088, 8'h00},
    {4'd4, 16'h5555, 8'h10}, {4'd5, 16'h0088, 8'h00},
    {4'd5, 16'h00C1, 8'h00}
  };

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic put_addr(logic [15:0] a);
    addr_in = a[15:8]; rc_n = 1'b0; step(2);
    addr_in = a[7:0];  rc_n = 1'b1; step(2);
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    put_addr(a);
    data_in = d; we_n = 1'b0; step(2);
    we_n = 1'b1; step(2);
  endtask

  task automatic rd(logic [15:0] a, output logic [7:0] v);
    put_addr(a);
    oe_n = 1'b0; step(3);
    v = data_out;
    oe_n = 1'b1; step(2);
  endtask

  task automatic send_prog(logic [15:0] a, logic [7:0] d);
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'hA0); wr(a, d);
  endtask

  task automatic send_erase(logic [15:0] a, logic [7:0] code);
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'h80);
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(a, code);
  endtask

  task automatic ref_erase(int kind, logic [15:0] a);
    for (int j = 0; j < 256; j++) begin
      if (kind == 4 || (kind == 2 && j / SEC_SZ == a[7:0] / SEC_SZ) ||
          (kind == 3 && j / BLK_SZ == a[7:0] / BLK_SZ))
        ref_mem[j] = 8'hFF;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    for (int j = 0; j < 256; j++) ref_mem[j] = 8'hFF;
    step(4);
    rst_n = 1'b1;
    step(2);

    // R10 R9: reset state, disabled output
    check("R9 output disabled", data_out, 8'h00);
    rd(16'h0000, v); check("R10 erased after reset", v, 8'hFF);
    rd(16'h00FF, v); check("R10 erased after reset top", v, 8'hFF);

    // R6: bad second cycle aborts
    wr(16'h5555, 8'hAA); wr(16'h1234, 8'h55); wr(16'h5555, 8'hA0); wr(16'h0010, 8'h00);
    rd(16'h0010, v); check("R6 abort on bad unlock", v, 8'hFF);

    // R2 R1: program, address halves from proper strobe edges
    send_prog(16'h00A5, 8'h00); ref_mem[8'hA5] = 8'h00;
    step(PROG_N + 4);
    rd(16'h00A5, v); check("R1 program at assembled address", v, 8'h00);
    rd(16'h0000, v); check("R1 halves not swapped", v, 8'hFF);

    // R6: unknown sixth code; R5: chip code at wrong address
    send_prog(16'h0020, 8'h00); ref_mem[8'h20] = 8'h00;
    step(PROG_N + 4);
    send_erase(16'h0020, 8'h20);
    rd(16'h0020, v); check("R6 unknown erase code ignored", v, 8'h00);
    send_erase(16'h1234, 8'h10);
    rd(16'h0020, v); check("R5 chip code off 5555h ignored", v, 8'h00);

    // table walk
    for (int k = 0; k < NV; k++) begin
      int kind;
      logic [15:0] a;
      logic [7:0] d;
      kind = int'(VEC[k][27:24]);
      a = VEC[k][23:8];
      d = VEC[k][7:0];
      case (kind)
        1: begin
          send_prog(a, d);
          rd(a, v); check("R8 program status", v, {~d[7], 1'b1, 6'b0});
          ref_mem[a[7:0]] = ref_mem[a[7:0]] & d;
          step(PROG_N + 4);
        end
        2, 3, 4: begin
          send_erase(a, d);
          rd(a, v); check("R8 erase status", v, 8'h40);
          ref_erase(kind, a);
          step(ERASE_N + 4);
        end
        default: begin
          rd(a, v);
          check($sformatf("R2 R3 R4 R5 array byte %02h", a[7:0]), v, ref_mem[a[7:0]]);
        end
      endcase
    end

    // R7 R8: writes ignored while busy, toggle sequence
    send_prog(16'h0020, 8'h00); step(PROG_N + 4);
    send_erase(16'h0025, 8'h30);
    rd(16'h0020, v); check("R8 toggle first read", v, 8'h40);
    rd(16'h0020, v); check("R8 toggle second read", v, 8'h00);
    send_prog(16'h0090, 8'h00);
    rd(16'h0020, v); check("R8 toggle third read", v, 8'h40);
    step(ERASE_N);
    rd(16'h0090, v); check("R7 write while busy ignored", v, 8'hFF);
    rd(16'h0020, v); check("R3 sector erased after busy", v, 8'hFF);
    send_prog(16'h0091, 8'h12); step(PROG_N + 4);
    rd(16'h0091, v); check("R7 decoder usable after busy", v, 8'h12);
    check("R9 output disabled after reads", data_out, 8'h00);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule